// File: doc/BRIEF.md
# Linear Burst Read Sequencer

This block is the memory-side control for a synchronous burst read port on a parallel flash-style device. A host presents a word address together with chip enable and address-valid. On the first qualifying clock edge the block captures the address and then walks through a wrapping linear burst, one transfer per clock. It presents each transfer on the data pins and raises an end-of-burst flag on the final one. Output enable only gates the pins. Chip enable aborts the sequence, a fresh address-valid pulse restarts it, and reset halts it and returns the configuration to asynchronous access.

Burst length (4, 8, 16 or 32 transfers, or unbounded) and bus width (one or two 16-bit words per transfer) come from a small configuration register. That register is loaded by a strobe. In asynchronous mode the clock plays no part in the read path: the word at the applied address is returned combinationally. The storage array sits outside the block. The block drives a word address and receives the word at that address and the word above it. The read stream has no back-pressure and no ready signal: a flash burst cannot be paused. Data pins and flag therefore use separate drive-enable outputs in place of a valid/ready pair.

Top module: `burst_rd_seq`

## Requirements
- R1: While reset is low, dq_oe and eob_oe are 0 and any burst is abandoned. After reset, the configuration is asynchronous mode, length code 0 and 16-bit width.
- R2: In asynchronous mode (cfg_sync=0), dq_o carries {16'h0, word at addr} combinationally whenever ce_n and oe_n are both low, and eob_oe stays 0.
- R3: In synchronous mode, a burst starts at a rising clock edge that samples ce_n=0 and adv_n=0 when the previous edge sampled adv_n=1. The first transfer is on dq_o in the cycle that follows that edge.
- R4: In 16-bit mode a burst of L transfers keeps the address bits above log2(L) fixed. The low log2(L) bits run start, start+1, … modulo L. Length codes on cfg_len are 0=4, 1=8, 2=16, 3=32.
- R5: In 32-bit mode (cfg_bus32=1) the start address has bit 0 cleared, and each transfer puts {word a+1, word a} on dq_o. The word address steps by 2 inside a window of 2L words. Code 3 gives 16 transfers in this mode.
- R6: eob_o is 1 during the last transfer of a bounded burst and only then. At the next edge the burst ends and dq_oe falls.
- R7: oe_n=1 forces dq_oe and eob_oe to 0 but does not pause the burst. Transfers missed while floated are skipped.
- R8: ce_n=1 drops dq_oe and eob_oe in the same cycle and ends the burst at the next edge. Taking ce_n low again without a new address-valid pulse does not resume it.
- R9: A new address-valid pulse during a burst discards the old address and starts a new burst at the new address. Holding adv_n low does not restart it on later edges.
- R10: Length codes 4 to 7 select an unbounded burst. The address increments linearly with no wrap, and eob_o stays 0.
- R11: cfg_sync, cfg_bus32 and cfg_len are captured only at an edge where cfg_load is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Strobe capturing the configuration inputs |
| cfg_sync | input | 1 | 1 selects synchronous burst mode |
| cfg_bus32 | input | 1 | 1 selects two words per transfer |
| cfg_len | input | 3 | Burst length code |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address from the host |
| mem_addr | output | ADDR_W | Word address to the storage array |
| mem_rdata | input | 2*DATA_W | Words at mem_addr+1 (upper) and mem_addr (lower) |
| dq_o | output | 2*DATA_W | Data pins value, zero when not driven |
| dq_oe | output | 1 | Drive enable for dq_o |
| eob_o | output | 1 | End-of-burst flag |
| eob_oe | output | 1 | Drive enable for eob_o |

## Verification
The hardest case to reach from the ports is a burst that keeps counting while its outputs are floated. Only the address of the transfer seen after output enable returns shows that the internal counter moved on. The stimulus lifts oe_n for two cycles in mid-burst and checks that the next visible word is the one two steps further on. A second hard case is telling a restart from a held address-valid. The restart test lowers adv_n mid-burst, keeps it low for one more edge, and expects the second address to advance rather than reload.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    LEN_4    = 3'd0,
    LEN_8    = 3'd1,
    LEN_16   = 3'd2,
    LEN_32   = 3'd3,
    LEN_CONT = 3'd4
  } burst_len_e;

  typedef struct packed {
    logic       sync;
    logic       bus32;
    logic [2:0] len;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_DEFAULT = '{sync: 1'b0, bus32: 1'b0, len: LEN_4};
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       sync_i,
  input  logic       bus32_i,
  input  logic [2:0] len_i,
  output burst_cfg_t cfg_o,
  output logic       cont_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= CFG_DEFAULT;
    end else if (load) begin
      cfg_o <= '{sync: sync_i, bus32: bus32_i, len: len_i};
    end
  end

  // any code above the largest bounded length runs without end
  assign cont_o = (cfg_o.len > 3'(LEN_32));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cfg_t        cfg,
  input  logic              cont,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              start,
  output logic              last,
  output logic [ADDR_W-1:0] ptr
);
  logic              adv_prev;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        xfer_log2;
  logic [2:0]        word_log2;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  cnt_last;

  always_comb begin
    unique case (cfg.len)
      3'(LEN_4):  xfer_log2 = 3'd2;
      3'(LEN_8):  xfer_log2 = 3'd3;
      3'(LEN_16): xfer_log2 = 3'd4;
      3'(LEN_32): xfer_log2 = cfg.bus32 ? 3'd4 : 3'd5;
      default:    xfer_log2 = 3'd5;
    endcase
  end

  assign word_log2  = xfer_log2 + {2'b00, cfg.bus32};
  assign win_mask   = cont ? {ADDR_W{1'b1}} : ~({ADDR_W{1'b1}} << word_log2);
  assign cnt_last   = ~({CNT_W{1'b1}} << xfer_log2);
  assign step       = cfg.bus32 ? ADDR_W'(2) : ADDR_W'(1);
  assign inc        = ptr + step;
  assign nxt        = (ptr & ~win_mask) | (inc & win_mask);
  assign start_addr = addr & ~ADDR_W'(cfg.bus32);

  assign start = cfg.sync && !ce_n && !adv_n && adv_prev;
  assign last  = active && !cont && (cnt == cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ptr      <= '0;
      cnt      <= '0;
      adv_prev <= 1'b1;
    end else begin
      adv_prev <= adv_n;
      if (start) begin
        active <= 1'b1;
        ptr    <= start_addr;
        cnt    <= '0;
      end else if (active) begin
        if (ce_n || last || !cfg.sync) begin
          active <= 1'b0;
        end else begin
          ptr <= nxt;
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              bus32,
  input  logic              active,
  input  logic              last,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [2*DATA_W-1:0] rdata,
  output logic [2*DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              eob_o,
  output logic              eob_oe
);
  logic pins_on;
  logic [2*DATA_W-1:0] shaped;

  assign pins_on = rst_n && !ce_n && !oe_n;
  assign dq_oe   = pins_on && (sync_mode ? active : 1'b1);
  assign eob_oe  = pins_on && sync_mode && active;
  assign eob_o   = active && last;
  assign shaped  = (sync_mode && bus32) ? rdata : {{DATA_W{1'b0}}, rdata[DATA_W-1:0]};
  assign dq_o    = dq_oe ? shaped : '0;
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int MAX_XFER_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic                cfg_sync,
  input  logic                cfg_bus32,
  input  logic [2:0]          cfg_len,
  input  logic                ce_n,
  input  logic                adv_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [2*DATA_W-1:0] mem_rdata,
  output logic [2*DATA_W-1:0] dq_o,
  output logic                dq_oe,
  output logic                eob_o,
  output logic                eob_oe
);
  localparam int CNT_W = MAX_XFER_LOG2;

  burst_cfg_t        cfg_q;
  logic              cont_mode;
  logic              active;
  logic              start;
  logic              last;
  logic [ADDR_W-1:0] ptr;
  logic              sync_mode;
  logic              bus32_mode;

  assign sync_mode  = cfg_q.sync;
  assign bus32_mode = cfg_q.bus32;

  burst_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .sync_i  (cfg_sync),
    .bus32_i (cfg_bus32),
    .len_i   (cfg_len),
    .cfg_o   (cfg_q),
    .cont_o  (cont_mode)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg_q),
    .cont   (cont_mode),
    .ce_n   (ce_n),
    .adv_n  (adv_n),
    .addr   (addr),
    .active (active),
    .start  (start),
    .last   (last),
    .ptr    (ptr)
  );

  assign mem_addr = sync_mode ? ptr : addr;

  burst_out_stage #(.DATA_W(DATA_W)) u_out (
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .bus32     (bus32_mode),
    .active    (active),
    .last      (last),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .rdata     (mem_rdata),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .eob_o     (eob_o),
    .eob_oe    (eob_oe)
  );
endmodule

// File: rtl/burst_rd_seq_chk.sv
module burst_rd_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              ce_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dq_oe,
  input logic              eob_o,
  input logic              eob_oe,
  input logic              sync_mode,
  input logic              bus32_mode,
  input logic              cont_mode,
  input logic              active
);
  logic adv_seen_high;
  logic begin_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_seen_high <= 1'b1;
    else        adv_seen_high <= adv_n;
  end

  assign begin_now = sync_mode && !ce_n && !adv_n && adv_seen_high && !cfg_load;

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_float_R1: assert (!dq_oe && !eob_oe);
    end
  end

  assert_async_no_eob_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !eob_oe);

  assert_start_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    begin_now |=> (mem_addr == ($past(addr) & ~ADDR_W'($past(bus32_mode)))));

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sync_mode && !cont_mode && !cfg_load && !(begin_now))
      |=> (mem_addr[ADDR_W-1:5] == $past(mem_addr[ADDR_W-1:5])));

  assert_eob_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_o && adv_n && !cfg_load) |=> !eob_o);

  assert_oe_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && !eob_oe));

  assert_ce_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dq_oe && !eob_oe));

  assert_cont_no_eob_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cont_mode |-> !eob_o);
endmodule

bind burst_rd_seq burst_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .ce_n       (ce_n),
  .adv_n      (adv_n),
  .oe_n       (oe_n),
  .addr       (addr),
  .mem_addr   (mem_addr),
  .dq_oe      (dq_oe),
  .eob_o      (eob_o),
  .eob_oe     (eob_oe),
  .sync_mode  (sync_mode),
  .bus32_mode (bus32_mode),
  .cont_mode  (cont_mode),
  .active     (active)
);

// File: tb/burst_rd_seq_bench.sv
module burst_rd_seq_bench;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_sync = 1'b0, cfg_bus32 = 1'b0;
  logic [2:0]  cfg_len = 3'd0;
  logic        ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [31:0] dq_o;
  logic        dq_oe, eob_o, eob_oe;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] word_at(input logic [15:0] a);
    return a * 16'd7 + 16'h1234;
  endfunction

  assign mem_rdata = {word_at(mem_addr + 16'd1), word_at(mem_addr)};

  burst_rd_seq u_burst_rd_seq (
    .clk, .rst_n, .cfg_load, .cfg_sync, .cfg_bus32, .cfg_len,
    .ce_n, .adv_n, .oe_n, .addr, .mem_addr, .mem_rdata,
    .dq_o, .dq_oe, .eob_o, .eob_oe
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(input logic s, input logic b, input logic [2:0] l);
    cfg_sync = s; cfg_bus32 = b; cfg_len = l; cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  function automatic logic [31:0] expect_dq(input logic [15:0] w, input logic b);
    return b ? {word_at(w + 16'd1), word_at(w)} : {16'h0, word_at(w)};
  endfunction

  // launch: leaves the first transfer visible
  task automatic launch(input logic [15:0] a);
    adv_n = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
    tick();
    ce_n = 1'b0; adv_n = 1'b0; addr = a;
    tick();
    adv_n = 1'b1;
  endtask

  // full bounded burst with per-transfer checks (R3 R4 R5 R6)
  task automatic bounded_burst(input string req, input logic [15:0] a, input int xlog, input logic b);
    int n = 1 << xlog;
    int wlog = xlog + (b ? 1 : 0);
    logic [15:0] mask = 16'((1 << wlog) - 1);
    logic [15:0] a0 = b ? (a & 16'hFFFE) : a;
    launch(a);
    for (int t = 0; t < n; t++) begin
      logic [15:0] w = (a0 & ~mask) | ((a0 + 16'(t * (b ? 2 : 1))) & mask);
      check(req, "dq", dq_o, expect_dq(w, b));
      check(req, "dq_oe", {31'b0, dq_oe}, 32'd1);
      check("R6", "eob", {31'b0, eob_o}, (t == n - 1) ? 32'd1 : 32'd0);
      tick();
    end
    check("R6", "end float", {31'b0, dq_oe}, 32'd0);
    ce_n = 1'b1;
  endtask

  task automatic t_reset_async();
    rst_n = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0; addr = 16'h0037;
    #3;
    check("R1", "dq_oe in reset", {31'b0, dq_oe}, 32'd0);
    check("R1", "eob_oe in reset", {31'b0, eob_oe}, 32'd0);
    tick(); tick();
    rst_n = 1'b1;
    #2;
    check("R2", "async dq", dq_o, {16'h0, word_at(16'h0037)});
    check("R2", "async eob_oe", {31'b0, eob_oe}, 32'd0);
    addr = 16'h0101;
    #1;
    check("R2", "async follows addr", dq_o, {16'h0, word_at(16'h0101)});
    oe_n = 1'b1;
    #1;
    check("R2", "async oe gate", {31'b0, dq_oe}, 32'd0);
    ce_n = 1'b1;
  endtask

  task automatic t_cfg_hold();
    // inputs change with no strobe: mode stays asynchronous (R11)
    cfg_sync = 1'b1; cfg_len = 3'd2;
    tick();
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 16'h0042;
    tick(); tick();
    addr = 16'h0050;
    #1;
    check("R11", "no strobe keeps async", dq_o, {16'h0, word_at(16'h0050)});
    ce_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic t_oe_float();
    load_cfg(1'b1, 1'b0, 3'd1);
    launch(16'h0020);
    tick(); tick();
    check("R7", "before float", dq_o, {16'h0, word_at(16'h0022)});
    oe_n = 1'b1;
    #1;
    check("R7", "floated dq_oe", {31'b0, dq_oe}, 32'd0);
    tick();
    check("R7", "floated eob_oe", {31'b0, eob_oe}, 32'd0);
    tick();
    oe_n = 1'b0;
    #1;
    check("R7", "count continued", dq_o, {16'h0, word_at(16'h0024)});
    ce_n = 1'b1;
    tick();
  endtask

  task automatic t_abort();
    load_cfg(1'b1, 1'b0, 3'd1);
    launch(16'h0030);
    tick();
    ce_n = 1'b1;
    #1;
    check("R8", "ce float now", {31'b0, dq_oe}, 32'd0);
    check("R8", "ce float eob", {31'b0, eob_oe}, 32'd0);
    tick();
    ce_n = 1'b0; adv_n = 1'b1;
    tick();
    check("R8", "no resume", {31'b0, dq_oe}, 32'd0);
    tick();
    check("R8", "no resume later", {31'b0, dq_oe}, 32'd0);
    ce_n = 1'b1;
  endtask

  task automatic t_restart();
    load_cfg(1'b1, 1'b0, 3'd1);
    launch(16'h0010);
    tick();
    adv_n = 1'b0; addr = 16'h0053;
    tick();
    check("R9", "new address", dq_o, {16'h0, word_at(16'h0053)});
    addr = 16'h0099;
    tick();
    check("R9", "held adv no reload", dq_o, {16'h0, word_at(16'h0054)});
    adv_n = 1'b1; ce_n = 1'b1;
    tick();
  endtask

  task automatic t_cont();
    load_cfg(1'b1, 1'b0, 3'd4);
    launch(16'h001E);
    for (int t = 0; t < 40; t++) begin
      check("R10", "linear dq", dq_o, {16'h0, word_at(16'h001E + 16'(t))});
      check("R10", "no eob", {31'b0, eob_o}, 32'd0);
      tick();
    end
    ce_n = 1'b1;
    tick();
  endtask

  task automatic t_reset_mid();
    load_cfg(1'b1, 1'b0, 3'd2);
    launch(16'h0060);
    tick();
    rst_n = 1'b0;
    #2;
    check("R1", "reset halts burst", {31'b0, dq_oe}, 32'd0);
    tick();
    rst_n = 1'b1;
    addr = 16'h0077; adv_n = 1'b0;
    tick();
    check("R1", "default async after reset", dq_o, {16'h0, word_at(16'h0077)});
    adv_n = 1'b1; ce_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset_async();
    t_cfg_hold();
    load_cfg(1'b1, 1'b0, 3'd2);
    check("R11", "strobe enables sync", {31'b0, eob_oe}, 32'd0);
    bounded_burst("R4", 16'h1235, 4, 1'b0);   // start 5, wraps mod 16
    load_cfg(1'b1, 1'b0, 3'd0);
    bounded_burst("R3", 16'h0402, 2, 1'b0);
    load_cfg(1'b1, 1'b0, 3'd3);
    bounded_burst("R4", 16'h005F, 5, 1'b0);   // start 31, wraps mod 32
    load_cfg(1'b1, 1'b1, 3'd0);
    bounded_burst("R5", 16'h0047, 2, 1'b1);   // bit 0 dropped, window 8 words
    load_cfg(1'b1, 1'b1, 3'd3);
    bounded_burst("R5", 16'h000A, 4, 1'b1);   // code 3 gives 16 transfers
    t_oe_float();
    t_abort();
    t_restart();
    t_cont();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule